// File: doc/BRIEF.md
# Programmable DDR Output Bit Crossbar

This block builds a double-data-rate parallel output bus from a pair of 14-bit converter samples, one from channel A and one from channel B. Every output pin carries two bits in each data-clock period, one in the rising half and one in the falling half. For each pin and each half, a select register chooses which source bit appears there. A select can name any bit of either channel. Its value can also name no bit, which forces the pin low for that half.

Both channel words are captured together when a sample strobe is present. One clock later, the two halves for every pin are formed from the captured pair and registered. The DDR cells themselves are modelled as a registered rising/falling output pair.

Software changes the mapping through a small address/data write port. Writes land in a shadow table. The shadow table is copied into the live table only at a sample boundary, so each output word is built from a single mapping.

Top module: `ddr_bit_xbar`

## Requirements
- R1: While reset is asserted, and in the cycle after it, both `q_rise` and `q_fall` are all zero. Reset also loads the default mapping described in R2.
- R2: After reset, pin n carries channel A bit n in the rising half and channel B bit n in the falling half. A sample strobed at clock edge k appears on `q_rise`/`q_fall` after edge k+1.
- R3: Write address bit 4 selects the half: 0 is rising, 1 is falling. Address bits 3:0 select the pin. The 5-bit write data is the new select value for that pin and half.
- R4: Select values 0 to 13 pick channel A bits 0 to 13. Select values 16 to 29 pick channel B bits 0 to 13.
- R5: Select values 14, 15, 30 and 31 drive a constant 0 on that pin and half.
- R6: A write to an address whose pin field is 14 or 15 changes no mapping.
- R7: A write made in a cycle without a sample strobe applies from the next strobed sample. A write made in the same cycle as a strobe applies from the strobe after that.
- R8: When no sample is strobed, both outputs hold their previous value, whatever the channel inputs do.
- R9: Several pins and halves may select the same source bit, and each of them carries that bit.
- R10: A mapping that places all channel B bits on the rising half and all channel A bits on the falling half swaps the two channels on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_vld | input | 1 | Sample boundary strobe: capture `ch_a`/`ch_b` and commit pending writes |
| ch_a | input | 14 | Channel A sample word |
| ch_b | input | 14 | Channel B sample word |
| cfg_we | input | 1 | Select table write enable |
| cfg_addr | input | 5 | Select table address: {half, pin} |
| cfg_wdata | input | 5 | Select value to write |
| q_rise | output | 14 | Bits driven in the rising half of the data clock |
| q_fall | output | 14 | Bits driven in the falling half of the data clock |

## Verification
A corrupted select register appears as a wrong bit on exactly one pin and one half. It shows up on the first output word formed after the next strobe, two edges after that strobe. A stale or early commit of the shadow table appears as a word built from the wrong mapping on the sample next to a write. A capture or hold fault appears within one cycle as outputs that change without a strobe. The bench drives random data so that any wrong bit differs from the expected word, and it compares every cycle against a behavioural model.

// File: rtl/xbar_pkg.sv
`timescale 1ns/1ps
package xbar_pkg;

  typedef enum logic {
    HALF_RISE = 1'b0,
    HALF_FALL = 1'b1
  } half_e;

  // Default select: rising half takes channel A bit p, falling half takes channel B bit p.
  function automatic int unsigned default_sel(input int half, input int pin, input int sel_w);
    int unsigned b_base;
    b_base = 1 << (sel_w - 1);
    if (half == 1) return b_base + pin;
    return pin;
  endfunction

endpackage

// File: rtl/xbar_cfg_regs.sv
`timescale 1ns/1ps
module xbar_cfg_regs #(
  parameter int PINS   = 14,
  parameter int SEL_W  = 5,
  parameter int ADDR_W = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic [SEL_W-1:0]          cfg_wdata,
  input  logic                      commit,
  output logic [2*PINS*SEL_W-1:0]   shd_flat,
  output logic [2*PINS*SEL_W-1:0]   act_flat
);
  import xbar_pkg::*;

  localparam int PIN_AW = ADDR_W - 1;

  logic [PIN_AW-1:0] pin_idx;
  logic              half_bit;
  logic              addr_ok;

  always_comb begin
    pin_idx  = cfg_addr[PIN_AW-1:0];
    half_bit = cfg_addr[ADDR_W-1];
    addr_ok  = ({{(32-PIN_AW){1'b0}}, pin_idx} < 32'(PINS));
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam logic HB = (h == 1) ? HALF_FALL : HALF_RISE;
    for (genvar p = 0; p < PINS; p++) begin : g_pin
      localparam logic [SEL_W-1:0] DEF = SEL_W'(default_sel(h, p, SEL_W));
      localparam int LSB = (h * PINS + p) * SEL_W;

      logic [SEL_W-1:0] shd_q;
      logic [SEL_W-1:0] act_q;
      logic             hit;

      assign hit = cfg_we && addr_ok && (half_bit == HB) && (pin_idx == PIN_AW'(p));

      always_ff @(posedge clk) begin
        if (rst)      shd_q <= DEF;
        else if (hit) shd_q <= cfg_wdata;
      end

      always_ff @(posedge clk) begin
        if (rst)         act_q <= DEF;
        else if (commit) act_q <= shd_q;
      end

      assign shd_flat[LSB +: SEL_W] = shd_q;
      assign act_flat[LSB +: SEL_W] = act_q;
    end
  end

endmodule

// File: rtl/xbar_capture.sv
`timescale 1ns/1ps
module xbar_capture #(
  parameter int CH_W = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic [CH_W-1:0] a_in,
  input  logic [CH_W-1:0] b_in,
  output logic [CH_W-1:0] cap_a,
  output logic [CH_W-1:0] cap_b,
  output logic            vld_d
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_a <= '0;
      cap_b <= '0;
      vld_d <= 1'b0;
    end else begin
      vld_d <= take;
      if (take) begin
        cap_a <= a_in;
        cap_b <= b_in;
      end
    end
  end

endmodule

// File: rtl/xbar_bit_mux.sv
`timescale 1ns/1ps
module xbar_bit_mux #(
  parameter int CH_W  = 14,
  parameter int SEL_W = 5
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [CH_W-1:0]  src_a,
  input  logic [CH_W-1:0]  src_b,
  output logic             bit_o
);

  localparam int IDX_W = SEL_W - 1;

  logic [IDX_W-1:0] idx;
  logic             use_b;

  always_comb begin
    idx   = sel[IDX_W-1:0];
    use_b = sel[SEL_W-1];
    bit_o = 1'b0;
    if ({{(32-IDX_W){1'b0}}, idx} < 32'(CH_W)) begin
      bit_o = use_b ? src_b[idx] : src_a[idx];
    end
  end

endmodule

// File: rtl/xbar_out_reg.sv
`timescale 1ns/1ps
module xbar_out_reg #(
  parameter int PINS = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [PINS-1:0] d_rise,
  input  logic [PINS-1:0] d_fall,
  output logic [PINS-1:0] q_rise,
  output logic [PINS-1:0] q_fall
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_rise <= '0;
      q_fall <= '0;
    end else if (load) begin
      q_rise <= d_rise;
      q_fall <= d_fall;
    end
  end

endmodule

// File: rtl/ddr_bit_xbar.sv
`timescale 1ns/1ps
module ddr_bit_xbar #(
  parameter int CH_W   = 14,
  parameter int PINS   = 14,
  parameter int SEL_W  = $clog2(CH_W) + 1,
  parameter int ADDR_W = $clog2(PINS) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              samp_vld,
  input  logic [CH_W-1:0]   ch_a,
  input  logic [CH_W-1:0]   ch_b,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [SEL_W-1:0]  cfg_wdata,
  output logic [PINS-1:0]   q_rise,
  output logic [PINS-1:0]   q_fall
);

  localparam int TBL_W = 2 * PINS * SEL_W;

  logic [TBL_W-1:0] shd_flat;
  logic [TBL_W-1:0] act_flat;
  logic [CH_W-1:0]  cap_a;
  logic [CH_W-1:0]  cap_b;
  logic             vld_d;
  logic [PINS-1:0]  nxt_rise;
  logic [PINS-1:0]  nxt_fall;

  xbar_cfg_regs #(
    .PINS   (PINS),
    .SEL_W  (SEL_W),
    .ADDR_W (ADDR_W)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .commit    (samp_vld),
    .shd_flat  (shd_flat),
    .act_flat  (act_flat)
  );

  xbar_capture #(
    .CH_W (CH_W)
  ) u_cap (
    .clk   (clk),
    .rst   (rst),
    .take  (samp_vld),
    .a_in  (ch_a),
    .b_in  (ch_b),
    .cap_a (cap_a),
    .cap_b (cap_b),
    .vld_d (vld_d)
  );

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    xbar_bit_mux #(
      .CH_W  (CH_W),
      .SEL_W (SEL_W)
    ) u_mux_r (
      .sel   (act_flat[p*SEL_W +: SEL_W]),
      .src_a (cap_a),
      .src_b (cap_b),
      .bit_o (nxt_rise[p])
    );

    xbar_bit_mux #(
      .CH_W  (CH_W),
      .SEL_W (SEL_W)
    ) u_mux_f (
      .sel   (act_flat[(PINS+p)*SEL_W +: SEL_W]),
      .src_a (cap_a),
      .src_b (cap_b),
      .bit_o (nxt_fall[p])
    );
  end

  xbar_out_reg #(
    .PINS (PINS)
  ) u_out (
    .clk    (clk),
    .rst    (rst),
    .load   (vld_d),
    .d_rise (nxt_rise),
    .d_fall (nxt_fall),
    .q_rise (q_rise),
    .q_fall (q_fall)
  );

endmodule

// File: rtl/xbar_chk.sv
`timescale 1ns/1ps
module xbar_chk #(
  parameter int CH_W  = 14,
  parameter int PINS  = 14,
  parameter int TBL_W = 140
) (
  input logic             clk,
  input logic             rst,
  input logic             samp_vld,
  input logic             cfg_we,
  input logic [CH_W-1:0]  cap_a,
  input logic [CH_W-1:0]  cap_b,
  input logic             vld_d,
  input logic [TBL_W-1:0] act_flat,
  input logic [TBL_W-1:0] shd_flat,
  input logic [PINS-1:0]  q_rise,
  input logic [PINS-1:0]  q_fall
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (q_rise == '0 && q_fall == '0));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !samp_vld |-> ##2 ($stable(q_rise) && $stable(q_fall)));

  assert_commit_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    !samp_vld |=> $stable(act_flat));

  assert_shadow_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(shd_flat));

  assert_zero_source_R5: assert property (@(posedge clk) disable iff (rst)
    (vld_d && cap_a == '0 && cap_b == '0) |=> (q_rise == '0 && q_fall == '0));

endmodule

bind ddr_bit_xbar xbar_chk #(
  .CH_W  (CH_W),
  .PINS  (PINS),
  .TBL_W (2 * PINS * SEL_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .samp_vld (samp_vld),
  .cfg_we   (cfg_we),
  .cap_a    (cap_a),
  .cap_b    (cap_b),
  .vld_d    (vld_d),
  .act_flat (act_flat),
  .shd_flat (shd_flat),
  .q_rise   (q_rise),
  .q_fall   (q_fall)
);

// File: tb/tb_ddr_bit_xbar.sv
`timescale 1ns/1ps
module tb_ddr_bit_xbar;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        samp_vld = 1'b0;
  logic [13:0] ch_a = '0;
  logic [13:0] ch_b = '0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [4:0]  cfg_wdata = '0;
  logic [13:0] q_rise;
  logic [13:0] q_fall;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit cmp_on = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  ddr_bit_xbar dut (
    .clk(clk), .rst(rst), .samp_vld(samp_vld), .ch_a(ch_a), .ch_b(ch_b),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .q_rise(q_rise), .q_fall(q_fall)
  );

  // Behavioural reference: tables indexed by write address.
  int          m_shd[32];
  int          m_act[32];
  logic [13:0] m_ca, m_cb, e_r, e_f;
  bit          m_vd;

  function automatic logic pick(int id, logic [13:0] a, logic [13:0] b);
    if (id >= 0 && id < 14) return a[id];
    if (id >= 16 && id < 30) return b[id-16];
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) begin m_shd[i] = i; m_act[i] = i; end
      m_ca = '0; m_cb = '0; e_r = '0; e_f = '0; m_vd = 0;
    end else begin
      if (m_vd) begin
        for (int p = 0; p < 14; p++) begin
          e_r[p] = pick(m_act[p], m_ca, m_cb);
          e_f[p] = pick(m_act[16+p], m_ca, m_cb);
        end
      end
      if (samp_vld) begin
        for (int i = 0; i < 32; i++) m_act[i] = m_shd[i];
        m_ca = ch_a; m_cb = ch_b;
      end
      m_vd = samp_vld;
      if (cfg_we && (int'(cfg_addr) % 16) < 14) m_shd[cfg_addr] = int'(cfg_wdata);
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      total++;
      if (q_rise !== e_r || q_fall !== e_f) begin
        bad++;
        $display("FAIL %s model: rise=%h fall=%h expected rise=%h fall=%h",
                 cur_req, q_rise, q_fall, e_r, e_f);
      end
    end
  end

  task automatic chk(string req, logic [13:0] got, logic [13:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(addr); cfg_wdata = 5'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(logic [13:0] a, logic [13:0] b);
    @(negedge clk);
    samp_vld = 1'b1; ch_a = a; ch_b = b;
    @(negedge clk);
    samp_vld = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [13:0] rev;
    repeat (4) @(negedge clk);
    chk("R1", q_rise, 14'h0);
    chk("R1", q_fall, 14'h0);
    rst = 1'b0;
    cmp_on = 1;
    @(negedge clk);
    chk("R1", q_rise | q_fall, 14'h0);

    // R2: default mapping and two-edge latency
    cur_req = "R2";
    send(14'h2A5C, 14'h1357);
    @(negedge clk);
    chk("R2", q_rise, 14'h2A5C);
    chk("R2", q_fall, 14'h1357);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      samp_vld = 1'b1; ch_a = 14'($urandom); ch_b = 14'($urandom);
    end
    @(negedge clk); samp_vld = 1'b0;

    // R8: inputs move without a strobe
    cur_req = "R8";
    send(14'h0F0F, 14'h3030);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ch_a = 14'($urandom); ch_b = 14'($urandom);
    end
    chk("R8", q_rise, 14'h0F0F);
    chk("R8", q_fall, 14'h3030);

    // R10: swapped channels
    cur_req = "R10";
    for (int p = 0; p < 14; p++) begin wr(p, 16 + p); wr(16 + p, p); end
    send(14'h1111, 14'h2222);
    @(negedge clk);
    chk("R10", q_rise, 14'h2222);
    chk("R10", q_fall, 14'h1111);

    // R3/R4: bit-reversed mapping
    cur_req = "R4";
    for (int p = 0; p < 14; p++) begin wr(p, 13 - p); wr(16 + p, 16 + 13 - p); end
    send(14'h0001, 14'h2000);
    @(negedge clk);
    chk("R3", q_rise, 14'h2000);
    chk("R4", q_fall, 14'h0001);

    // R5: values naming no bit drive zero
    cur_req = "R5";
    wr(0, 14); wr(1, 15); wr(16, 30); wr(17, 31);
    send(14'h3FFF, 14'h3FFF);
    @(negedge clk);
    chk("R5", q_rise, 14'h3FFC);
    chk("R5", q_fall, 14'h3FFC);

    // R6: pin fields 14/15 are not registers
    cur_req = "R6";
    wr(14, 0); wr(15, 0); wr(30, 16); wr(31, 16);
    send(14'h3FFF, 14'h3FFF);
    @(negedge clk);
    chk("R6", q_rise, 14'h3FFC);
    chk("R6", q_fall, 14'h3FFC);

    // R7: commit timing
    cur_req = "R7";
    for (int p = 0; p < 14; p++) begin wr(p, p); wr(16 + p, 16 + p); end
    send(14'h0000, 14'h0000);
    wr(0, 16);                       // idle write: next sample uses it
    send(14'h0000, 14'h0001);
    @(negedge clk);
    chk("R7", q_rise, 14'h0001);
    @(negedge clk);
    samp_vld = 1'b1; ch_a = 14'h0000; ch_b = 14'h0001;
    cfg_we = 1'b1; cfg_addr = 5'd0; cfg_wdata = 5'd14;   // same-cycle write
    @(negedge clk);
    samp_vld = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
    chk("R7", q_rise, 14'h0001);
    send(14'h3FFF, 14'h3FFF);
    @(negedge clk);
    chk("R7", q_rise, 14'h3FFE);

    // R9: one source bit fanned out to every pin and half
    cur_req = "R9";
    for (int p = 0; p < 14; p++) begin wr(p, 5); wr(16 + p, 21); end
    send(14'h0020, 14'h0000);
    @(negedge clk);
    chk("R9", q_rise, 14'h3FFF);
    chk("R9", q_fall, 14'h0000);

    // Random mix of writes and samples (R3, R4, R7)
    cur_req = "R3";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      samp_vld  = ($urandom % 3) != 0;
      ch_a      = 14'($urandom);
      ch_b      = 14'($urandom);
      cfg_we    = ($urandom % 4) == 0;
      cfg_addr  = 5'($urandom);
      cfg_wdata = 5'($urandom);
    end
    @(negedge clk);
    samp_vld = 1'b0; cfg_we = 1'b0;
    repeat (3) @(negedge clk);

    // Reset mid-run restores defaults (R1, R2)
    cur_req = "R1";
    rst = 1'b1;
    @(negedge clk);
    chk("R1", q_rise | q_fall, 14'h0);
    rst = 1'b0;
    cur_req = "R2";
    send(14'h1ABC, 14'h0DEF);
    @(negedge clk);
    chk("R2", q_rise, 14'h1ABC);
    chk("R2", q_fall, 14'h0DEF);
    finish_run();
  end

endmodule